// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. Each frame has a low start bit, then eight data bits or eight data bits plus a ninth bit, sent least significant bit first, then one high stop bit. A baud tick input sets the timing, and every bit lasts a fixed number of ticks. A one-entry holding register sits in front of the shifter. Software can therefore queue the next character while the current one is still being sent, and consecutive frames leave the line with no idle time between them.

A double-buffer enable selects between two interrupt schemes. With it clear, the block is a plain single-buffered transmitter. It raises its interrupt flag when the stop bit finishes, and it drops any write made while it is busy. With it set, the flag means "room for another character". The flag rises whenever a character moves into the shifter. An end-of-transmission select adds one more interrupt when the last frame finishes with nothing queued. The flag stays set until a clear strobe or reset.

Top module: `uart_dbuf_tx`

## Requirements
- R1: While reset is high and on the cycle after it is released, `txd` is 1, `tx_int` is 0 and `busy` is 0.
- R2: A frame is a start bit of 0, then the data bits LSB first, then a stop bit of 1. There are 8 data bits when `mode9`=0. When `mode9`=1 there are 9, and the ninth is `wr_bit9`. Each bit lasts TICKS (default 16) baud ticks. `mode9` is sampled when the character enters the shifter.
- R3: With `dbuf_en`=0, a write while idle starts a frame. On the next cycle `txd` is 0. `tx_int` becomes 1 on the cycle after the clock edge on which the stop bit's last tick is counted.
- R4: With `dbuf_en`=0, a write while a frame is in progress is dropped and produces no frame.
- R5: With `dbuf_en`=1, a write while idle with the holding register empty goes straight into the shifter. `tx_int` is 1 on the next cycle.
- R6: With `dbuf_en`=1, a write during a frame is held. On the edge that ends the current stop bit, the held character enters the shifter and `tx_int` is set. On the next cycle `txd` is the new start bit (0), so exactly one stop bit separates the two frames.
- R7: With `dbuf_en`=1, a write while the holding register is full, and the held character is not leaving it on that edge, is dropped.
- R8: With `dbuf_en`=1, when a frame ends and nothing is queued, `tx_int` is set if `eot_sel`=1 and left unchanged if `eot_sel`=0.
- R9: `tx_int` stays 1 until a cycle with `int_clr`=1 and no new set event. A set event on the same edge wins over the clear.
- R10: `busy` is 1 exactly while a frame is being shifted or the holding register is full. `txd` is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle baud enable; TICKS of these make one bit |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | DATA_W | Character to send |
| wr_bit9 | input | 1 | Ninth bit sent in 9-bit mode |
| mode9 | input | 1 | 0: 8 data bits, 1: 9 data bits |
| dbuf_en | input | 1 | 1: holding register in use, interrupt on buffer ready |
| eot_sel | input | 1 | 1: extra interrupt when the last frame ends (double-buffer mode) |
| int_clr | input | 1 | Clears the interrupt flag |
| txd | output | 1 | Serial line, idles high |
| tx_int | output | 1 | Transmit interrupt flag |
| busy | output | 1 | Frame in progress or character held |

## Verification
The single-buffered mode runs with a baud tick on every cycle. In this mode the line is sampled at the centre of every bit for 8-bit and 9-bit frames, which shows whether bit order, the ninth bit and the bit length are right. A second write made mid-frame shows whether such a write is dropped. The double-buffered mode runs with a tick every other cycle. An idle write, a queued write and a write into a full holding register show apart the direct load, the one-stop-bit handover and the dropped write, and running with `eot_sel` at 0 and then at 1 shows whether the extra end interrupt appears. A long randomized stream of writes, clears and mode changes is compared cycle by cycle against a queue-based reference model.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Where the shifter takes its next character from on a given edge
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_WRITE = 2'd1,
    SRC_HOLD  = 2'd2
  } load_src_e;
endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W = 8,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_bit9,
  input  logic              ld_nine,
  output logic              active,
  output logic              done,
  output logic              txd
);
  localparam int FW = DATA_W + 3;
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] frame_q;
  logic [CW-1:0] tick_q;
  logic [LW-1:0] left_q;
  logic          active_q;
  logic          txd_q;
  logic          bit_end;

  assign bit_end = active_q && baud_tick && (tick_q == CW'(TICKS - 1));
  assign done    = bit_end && (left_q == LW'(1));
  assign active  = active_q;
  assign txd     = txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      frame_q  <= '1;
      tick_q   <= '0;
      left_q   <= '0;
      txd_q    <= 1'b1;
    end else if (load) begin
      active_q <= 1'b1;
      frame_q  <= {1'b1, (ld_nine ? ld_bit9 : 1'b1), ld_data, 1'b0};
      tick_q   <= '0;
      left_q   <= ld_nine ? LW'(DATA_W + 3) : LW'(DATA_W + 2);
      txd_q    <= 1'b0;
    end else if (active_q && baud_tick) begin
      if (bit_end) begin
        tick_q <= '0;
        if (left_q == LW'(1)) begin
          active_q <= 1'b0;
          txd_q    <= 1'b1;
        end else begin
          frame_q <= {1'b1, frame_q[FW-1:1]};
          left_q  <= left_q - LW'(1);
          txd_q   <= frame_q[1];
        end
      end else begin
        tick_q <= tick_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_bit9,
  input  logic              take,
  output logic              valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_bit9
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              b9_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      b9_q    <= 1'b0;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        data_q  <= in_data;
        b9_q    <= in_bit9;
      end else if (take) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid    = valid_q;
  assign out_data = data_q;
  assign out_bit9 = b9_q;
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic      dbuf_en,
  input  logic      eot_sel,
  input  logic      int_clr,
  input  logic      sh_active,
  input  logic      sh_done,
  input  logic      hold_valid,
  output load_src_e src,
  output logic      hold_accept,
  output logic      tx_int
);
  logic free;
  logic set_int;
  logic int_q;

  always_comb begin
    free = dbuf_en ? (!sh_active || sh_done) : !sh_active;
    if (dbuf_en && free && hold_valid)
      src = SRC_HOLD;
    else if (free && !hold_valid && wr_en)
      src = SRC_WRITE;
    else
      src = SRC_NONE;
    hold_accept = dbuf_en && wr_en && (src != SRC_WRITE) &&
                  (!hold_valid || (src == SRC_HOLD));
    if (dbuf_en)
      set_int = (src != SRC_NONE) || (sh_done && eot_sel);
    else
      set_int = sh_done;
  end

  always_ff @(posedge clk) begin
    if (rst)
      int_q <= 1'b0;
    else if (set_int)
      int_q <= 1'b1;
    else if (int_clr)
      int_q <= 1'b0;
  end

  assign tx_int = int_q;
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              mode9,
  input  logic              dbuf_en,
  input  logic              eot_sel,
  input  logic              int_clr,
  output logic              txd,
  output logic              tx_int,
  output logic              busy
);
  load_src_e         src;
  logic              hold_accept;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              hold_b9;
  logic              sh_active;
  logic              sh_done;
  logic              sh_load;
  logic [DATA_W-1:0] ld_data;
  logic              ld_b9;

  uart_tx_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .dbuf_en    (dbuf_en),
    .eot_sel    (eot_sel),
    .int_clr    (int_clr),
    .sh_active  (sh_active),
    .sh_done    (sh_done),
    .hold_valid (hold_valid),
    .src        (src),
    .hold_accept(hold_accept),
    .tx_int     (tx_int)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .accept  (hold_accept),
    .in_data (wr_data),
    .in_bit9 (wr_bit9),
    .take    (src == SRC_HOLD),
    .valid   (hold_valid),
    .out_data(hold_data),
    .out_bit9(hold_b9)
  );

  assign sh_load = (src != SRC_NONE);
  assign ld_data = (src == SRC_HOLD) ? hold_data : wr_data;
  assign ld_b9   = (src == SRC_HOLD) ? hold_b9 : wr_bit9;

  uart_tx_shift #(.DATA_W(DATA_W), .TICKS(TICKS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .baud_tick(baud_tick),
    .load     (sh_load),
    .ld_data  (ld_data),
    .ld_bit9  (ld_b9),
    .ld_nine  (mode9),
    .active   (sh_active),
    .done     (sh_done),
    .txd      (txd)
  );

  assign busy = sh_active || hold_valid;
endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              baud_tick,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_bit9,
  input logic              mode9,
  input logic              dbuf_en,
  input logic              eot_sel,
  input logic              int_clr,
  input logic              txd,
  input logic              tx_int,
  input logic              busy
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (txd && !tx_int && !busy));

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> busy);

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(baud_tick) && !$past(wr_en)) |-> $stable(txd));

  // R9
  int_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_int && !int_clr) |=> tx_int);

  // R3
  conv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbuf_en && !baud_tick && !tx_int) |=> !tx_int);
endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/uart_dbuf_tx_test.sv
module uart_dbuf_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int TK = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          baud_tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_bit9 = 1'b0;
  logic          mode9 = 1'b0;
  logic          dbuf_en = 1'b0;
  logic          eot_sel = 1'b0;
  logic          int_clr = 1'b0;
  logic          txd, tx_int, busy;

  int total = 0;
  int bad = 0;
  int tick_div = 1;
  bit finished = 0;

  uart_dbuf_tx #(.DATA_W(DW), .TICKS(TK)) uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .mode9(mode9),
    .dbuf_en(dbuf_en), .eot_sel(eot_sel), .int_clr(int_clr),
    .txd(txd), .tx_int(tx_int), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // baud tick pattern, driven on falling edges
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = c + 1;
      baud_tick = (tick_div <= 1) ? 1'b1 : ((c % tick_div) == 0);
    end
  end

  // ---------------- reference model ----------------
  bit         m_bits[$];
  logic [8:0] m_hold[$];
  int         m_tick = 0;
  bit         m_int = 0;

  task automatic m_build(input logic [8:0] v);
    m_bits.delete();
    m_bits.push_back(1'b0);
    for (int i = 0; i < (mode9 ? 9 : 8); i++) m_bits.push_back(v[i]);
    m_bits.push_back(1'b1);
    m_tick = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_bits.delete(); m_hold.delete(); m_tick = 0; m_int = 0;
    end else begin
      bit act, dn, fr, fh, dr, st;
      logic [8:0] v;
      act = m_bits.size() != 0;
      dn  = act && baud_tick && (m_tick == TK - 1) && (m_bits.size() == 1);
      fr  = dbuf_en ? (!act || dn) : !act;
      fh  = dbuf_en && fr && (m_hold.size() != 0);
      dr  = fr && (m_hold.size() == 0) && wr_en;
      if (act && baud_tick) begin
        if (m_tick == TK - 1) begin m_tick = 0; void'(m_bits.pop_front()); end
        else m_tick = m_tick + 1;
      end
      st = dbuf_en ? (fh || dr || (dn && eot_sel)) : dn;
      if (fh) begin v = m_hold.pop_front(); m_build(v); end
      else if (dr) m_build({wr_bit9, wr_data});
      if (dbuf_en && wr_en && !dr && m_hold.size() == 0) m_hold.push_back({wr_bit9, wr_data});
      if (st) m_int = 1; else if (int_clr) m_int = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic e_txd, e_busy;
      e_txd  = (m_bits.size() != 0) ? m_bits[0] : 1'b1;
      e_busy = (m_bits.size() != 0) || (m_hold.size() != 0);
      total = total + 3;
      if (txd !== e_txd) begin bad++; $display("FAIL R2 model txd act=%b exp=%b t=%0t", txd, e_txd, $time); end
      if (tx_int !== m_int) begin bad++; $display("FAIL R9 model tx_int act=%b exp=%b t=%0t", tx_int, m_int, $time); end
      if (busy !== e_busy) begin bad++; $display("FAIL R10 model busy act=%b exp=%b t=%0t", busy, e_busy, $time); end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic b9);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_bit9 = b9;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  // conventional frame, tick every cycle, samples each bit centre
  task automatic frame_sample(input logic [7:0] d, input logic b9, input bit nine, input string req);
    int nb;
    logic [10:0] got, exp;
    nb = nine ? 11 : 10;
    exp = nine ? {1'b1, b9, d, 1'b0} : {1'b0, 1'b1, d, 1'b0};
    got = '0;
    do_write(d, b9);
    for (int k = 0; k < nb; k++) begin
      repeat ((k == 0) ? 8 : 16) @(negedge clk);
      got[k] = txd;
    end
    chk(req, got, exp);
    repeat (7) @(negedge clk);
    chk("R3 no int before stop end", tx_int, 1'b0);
    @(negedge clk);
    chk("R3 int at stop end", tx_int, 1'b1);
    chk("R3 idle after frame", busy, 1'b0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk("R1 txd in reset", txd, 1'b1);
    chk("R1 int in reset", tx_int, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 txd after reset", txd, 1'b1);

    // conventional, 8-bit and 9-bit frames
    frame_sample(8'hA5, 1'b0, 1'b0, "R2 8-bit frame");
    pulse_clr();
    chk("R9 cleared", tx_int, 1'b0);
    mode9 = 1'b1;
    frame_sample(8'h35, 1'b1, 1'b1, "R2 9-bit frame");
    pulse_clr();
    mode9 = 1'b0;

    // R4: write during busy is dropped
    do_write(8'h3C, 1'b0);
    repeat (20) @(negedge clk);
    do_write(8'hFF, 1'b0);
    wait_idle(cyc);
    repeat (40) @(negedge clk);
    chk("R4 no second frame", busy, 1'b0);
    chk("R4 line idle", txd, 1'b1);
    pulse_clr();

    // R9: flag persists without clear
    do_write(8'h01, 1'b0);
    wait_idle(cyc);
    repeat (30) @(negedge clk);
    chk("R9 flag held", tx_int, 1'b1);
    pulse_clr();

    // double buffering, tick every other cycle
    tick_div = 2; dbuf_en = 1'b1; eot_sel = 1'b0;
    repeat (4) @(negedge clk);
    do_write(8'h5A, 1'b0);
    chk("R5 immediate int", tx_int, 1'b1);
    chk("R5 start bit", txd, 1'b0);
    pulse_clr();
    repeat (40) @(negedge clk);
    do_write(8'hC3, 1'b0);
    chk("R10 busy with held char", busy, 1'b1);
    repeat (20) @(negedge clk);
    do_write(8'h99, 1'b0);
    cyc = 0;
    while (!tx_int && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R6 handover int", tx_int, 1'b1);
    chk("R6 next start bit at once", txd, 1'b0);
    pulse_clr();
    wait_idle(cyc);
    chk("R7 only one more frame", (cyc > 300 && cyc < 330), 1'b1);
    repeat (5) @(negedge clk);
    chk("R8 no end int when eot_sel=0", tx_int, 1'b0);

    // R8 with eot_sel=1
    eot_sel = 1'b1;
    do_write(8'h42, 1'b0);
    pulse_clr();
    chk("R8 cleared before end", tx_int, 1'b0);
    cyc = 0;
    while (busy && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R8 end int with eot_sel=1", tx_int, 1'b1);
    pulse_clr();

    // randomized stream against the model
    tick_div = 1;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      wr_en   = ($urandom_range(0, 99) < 4);
      wr_data = 8'($urandom);
      wr_bit9 = 1'($urandom);
      int_clr = ($urandom_range(0, 99) < 10);
      if ((n % 4000) == 0 && !busy) begin
        mode9   = 1'($urandom);
        eot_sel = 1'($urandom);
        dbuf_en = 1'($urandom);
      end
    end
    @(negedge clk);
    wr_en = 1'b0; int_clr = 1'b0;
    wait_idle(cyc);
    repeat (5) @(negedge clk);
    chk("R10 idle at end", busy, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    finished = 1;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule